// File: doc/BRIEF.md
# Programmable Interrupt Countdown Timer

This block is a 32-bit down-counter that raises an interrupt request when it runs out. A free-running base tick comes in and passes through a prescaler whose ratio is a power of two. Each time the prescaler wraps, the counter steps down by one. A small register-write port sets three things: the divide ratio, the starting count, and a timer entry. The timer entry holds the interrupt vector, a mask bit and the counting mode.

In single-shot mode the counter stops at zero after one request. In repeating mode it reloads from the starting count and fires once per period. Writing a starting count of zero parks the timer. Each request is a one-cycle strobe that carries the vector. The strobe always signals fixed delivery and edge triggering, so an interrupt controller can latch it directly.

Top module: `irq_countdown_timer`

## Requirements
- R1: The divide ratio comes from a 3-bit code built as {cfg[3], cfg[1:0]}. Code 3'b111 divides by 1, and any other code n divides by 2^(n+1). The count steps down by one on every divided tick and never changes on a cycle without a base tick.
- R2: The timer entry selects the counting mode in bits [18:17]. Value 0 is single-shot and value 1 is repeating. With values 2 and 3 the count runs down to 0 and stays there with no request.
- R3: A write of the starting count (wr_sel 2'd1) loads both the starting count and the current count, and restarts the prescaler from zero. That write wins over a divided tick in the same cycle.
- R4: While the current count is 0, base ticks do not change it and no request is raised.
- R5: In single-shot mode, the divided tick that takes the count from 1 to 0 leaves it at 0 and raises exactly one request.
- R6: In repeating mode, the divided tick that ends a period reloads the starting count and raises a request. This happens every period.
- R7: A request is a one-cycle irq_valid strobe in the cycle after the expiring tick. It carries entry bits [7:0] on irq_vector, irq_dmode = 3'b000 (fixed) and irq_trig = 0 (edge).
- R8: Entry bit 16 masks requests without stopping the counting or the reloading. After reset the entry holds 32'h0001_0000, which is masked, single-shot, vector 0.
- R9: A write with wr_sel 2'd3 (current count) is ignored. A write with wr_sel 2'd0 loads the divide configuration, and a write with wr_sel 2'd2 loads the timer entry.
- R10: After reset the current count is 0 and irq_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Base tick, one cycle per tick |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 divide, 1 starting count, 2 entry, 3 current count |
| wr_data | input | 32 | Write data |
| cur_count | output | 32 | Current count |
| irq_valid | output | 1 | Request strobe |
| irq_vector | output | 8 | Request vector |
| irq_dmode | output | 3 | Delivery mode, always fixed (0) |
| irq_trig | output | 1 | Trigger mode, always edge (0) |

## Verification
All eight divide codes run a single-shot countdown from 3. The bench samples the count one tick before expiry, at expiry, and well after it. This tells the divide-by-1 code apart from the shifted codes, and shows that an off-by-one prescaler or a missing stop at zero is wrong. Repeating mode runs once unmasked and once masked, to separate reload from delivery. The reserved modes, writes to the read-only count, a restart partway through a prescaler cycle, and a zero starting count each cover one corner of loading and idling.

// File: rtl/irq_countdown_timer.sv
module irq_countdown_timer #(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8,
  parameter int PS_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cur_count,
  output logic             irq_valid,
  output logic [VEC_W-1:0] irq_vector,
  output logic [2:0]       irq_dmode,
  output logic             irq_trig
);
  localparam int MASK_BIT = 16;
  localparam int MODE_LO  = 17;
  localparam int ENT_W    = MODE_LO + 2;
  localparam logic [ENT_W-1:0] ENT_RST = ENT_W'(1) << MASK_BIT;

  logic [2:0]       div_code;
  logic [CNT_W-1:0] init_q;
  logic [ENT_W-1:0] entry_q;
  logic [PS_W-1:0]  presc;
  logic [2:0]       shift;
  logic [PS_W-1:0]  lim_m1;
  logic             init_wr, step, expire, periodic, deliverable;
  logic [1:0]       mode;

  assign init_wr     = wr_en && (wr_sel == 2'd1);
  assign shift       = (div_code == 3'b111) ? 3'd0 : div_code + 3'd1;
  assign lim_m1      = (PS_W'(1) << shift) - PS_W'(1);
  assign step        = tick && (presc >= lim_m1);
  assign expire      = step && !init_wr && (cur_count == CNT_W'(1));
  assign mode        = entry_q[MODE_LO +: 2];
  assign periodic    = (mode == 2'd1);
  assign deliverable = !entry_q[MASK_BIT] && (mode == 2'd0 || mode == 2'd1);
  assign irq_dmode   = 3'b000;
  assign irq_trig    = 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_code <= 3'd0;
      entry_q  <= ENT_RST;
      init_q   <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        2'd0: div_code <= {wr_data[3], wr_data[1:0]};
        2'd1: init_q   <= wr_data;
        2'd2: entry_q  <= wr_data[ENT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       presc <= '0;
    else if (init_wr) presc <= '0;
    else if (tick)    presc <= step ? '0 : presc + PS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cur_count <= '0;
    else if (init_wr)
      cur_count <= wr_data;
    else if (step && cur_count != '0)
      cur_count <= (cur_count == CNT_W'(1)) ? (periodic ? init_q : '0)
                                            : cur_count - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_valid  <= 1'b0;
      irq_vector <= '0;
    end else begin
      irq_valid <= expire && deliverable;
      if (expire) irq_vector <= entry_q[VEC_W-1:0];
    end
  end
endmodule

module irq_countdown_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             wr_en,
  input logic [1:0]       wr_sel,
  input logic [CNT_W-1:0] cur_count,
  input logic [CNT_W-1:0] init_q,
  input logic             mask_bit,
  input logic             irq_valid
);
  assert_no_tick_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable(cur_count));

  assert_step_by_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && cur_count != '0) |=> (cur_count == $past(cur_count) ||
      cur_count == $past(cur_count) - CNT_W'(1) || cur_count == init_q));

  assert_idle_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_count == '0 && !(wr_en && wr_sel == 2'd1)) |=> (cur_count == '0));

  assert_expire_from_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> ($past(cur_count) == CNT_W'(1)));

  assert_masked_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> !$past(mask_bit));

  assert_readonly_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd3 && !tick) |=> $stable(cur_count));
endmodule

bind irq_countdown_timer irq_countdown_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
  .cur_count(cur_count), .init_q(init_q), .mask_bit(entry_q[16]),
  .irq_valid(irq_valid)
);

// File: tb/tb_irq_countdown_timer.sv
`timescale 1ns/1ps
module tb_irq_countdown_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [31:0] cur_count;
  logic        irq_valid;
  logic [7:0]  irq_vector;
  logic [2:0]  irq_dmode;
  logic        irq_trig;

  int errors = 0, checks = 0, irq_cnt = 0;
  logic [7:0] last_vec = '0;
  logic bad_fields = 1'b0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  irq_countdown_timer dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .cur_count(cur_count), .irq_valid(irq_valid),
    .irq_vector(irq_vector), .irq_dmode(irq_dmode), .irq_trig(irq_trig)
  );

  always @(posedge clk) if (irq_valid) begin
    irq_cnt++;
    last_vec = irq_vector;
    if (irq_dmode != 3'd0 || irq_trig != 1'b0) bad_fields = 1'b1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [31:0] cfg_of(input int c);
    return {28'd0, c[2], 1'b0, c[1:0]};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset count", cur_count, 0);
    chk("R10 reset strobe", {31'd0, irq_valid}, 0);

    wr(2'd0, 32'hB);
    wr(2'd1, 2);
    ticks(3);
    chk("R8 reset entry masked count", cur_count, 0);
    chk("R8 reset entry masked irq", irq_cnt, 0);

    for (int c = 0; c < 8; c++) begin
      int lim;
      lim = (c == 7) ? 1 : (2 << c);
      irq_cnt = 0;
      wr(2'd0, cfg_of(c));
      wr(2'd2, 32'h40 + c);
      wr(2'd1, 3);
      ticks(3 * lim - 1);
      chk($sformatf("R1 code %0d before expiry", c), cur_count, 1);
      chk($sformatf("R5 code %0d no early irq", c), irq_cnt, 0);
      ticks(1);
      chk($sformatf("R5 code %0d count zero", c), cur_count, 0);
      chk($sformatf("R5 code %0d one irq", c), irq_cnt, 1);
      chk($sformatf("R7 code %0d vector", c), last_vec, 32'h40 + c);
      ticks(2 * lim);
      chk($sformatf("R4 code %0d stays zero", c), cur_count, 0);
      chk($sformatf("R4 code %0d no more irq", c), irq_cnt, 1);
    end
    chk("R7 fixed edge fields", {31'd0, bad_fields}, 0);

    irq_cnt = 0;
    wr(2'd0, cfg_of(0));
    wr(2'd2, (32'd1 << 17) | 32'h55);
    wr(2'd1, 4);
    ticks(24);
    chk("R6 periodic irq count", irq_cnt, 3);
    chk("R6 periodic reload", cur_count, 4);
    chk("R7 periodic vector", last_vec, 32'h55);
    ticks(2);
    chk("R6 periodic continues", cur_count, 3);

    irq_cnt = 0;
    wr(2'd2, (32'd1 << 17) | (32'd1 << 16) | 32'h66);
    wr(2'd1, 4);
    ticks(24);
    chk("R8 masked no irq", irq_cnt, 0);
    chk("R8 masked still reloads", cur_count, 4);

    irq_cnt = 0;
    wr(2'd0, 32'hB);
    wr(2'd2, (32'd2 << 17) | 32'h77);
    wr(2'd1, 5);
    ticks(5);
    chk("R2 mode2 count zero", cur_count, 0);
    chk("R2 mode2 no irq", irq_cnt, 0);
    ticks(3);
    chk("R2 mode2 stays zero", cur_count, 0);

    wr(2'd1, 9);
    wr(2'd3, 32'h1234);
    chk("R9 current count write ignored", cur_count, 9);
    ticks(2);
    chk("R9 counts after ignored write", cur_count, 7);

    irq_cnt = 0;
    wr(2'd1, 0);
    ticks(4);
    chk("R3 zero start parks", cur_count, 0);
    chk("R4 zero start no irq", irq_cnt, 0);

    wr(2'd0, cfg_of(2));
    wr(2'd1, 10);
    ticks(5);
    chk("R3 mid prescale", cur_count, 10);
    wr(2'd1, 10);
    ticks(7);
    chk("R3 prescaler restarted", cur_count, 10);
    ticks(1);
    chk("R3 first step after restart", cur_count, 9);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule